// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit derives the nominal bit timing of a CAN node from the system oscillator clock. A prescaler divides the clock into time quanta. Each bit is laid out as a one-quantum sync segment, then a propagation segment, then phase segment 1 and phase segment 2. The receive line is read where phase segment 1 ends. The read uses either a single sample or a majority vote over three samples taken half a quantum apart. While the bus is idle (`sof_en` high), a falling edge on `rx` hard-synchronizes the bit grid. Inside a frame (`sof_en` low), a falling edge moves the grid by resynchronization, and the jump width limits how far it can move.

The outputs are plain strobes and a level. The unit has no data stream and no handshake, so nothing can push back on it. `sample_pulse` marks the clock in which `rx_bit` takes a new value. `bit_start` marks the first clock of each bit. A downstream frame decoder must take both strobes in the cycle they appear. `cfg_err` is combinational from the configuration fields. While it is high, the unit runs on a safe fallback timing.

Line levels: `rx` = 1 is recessive and `rx` = 0 is dominant. Quanta within a bit are indexed from 0, where index 0 is the sync segment.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts 2·(cfg_brp+1) clocks. A bit lasts (1+P+A+B) quanta, where P = cfg_prop+1, A = cfg_ps1+1 and B = cfg_ps2+1 (each field holds its length minus one). bit_start is high for the first clock of every bit.
- R2: sample_pulse is high for one clock, (1+P+A)·2·(cfg_brp+1) clocks after the bit_start of an unadjusted bit. rx_bit changes only in that clock.
- R3: With cfg_triple = 0, rx_bit takes the level rx had two clock edges before sample_pulse is seen.
- R4: With cfg_triple = 1, rx_bit is the majority of three registered rx samples. They are taken at the sample point and at the two earlier half-quantum ticks, with the ticks spaced cfg_brp+1 clocks apart.
- R5: cfg_err is high when any of these holds: 1+P+A+B < 8, 1+P+A+B > 25, P+A < B, B ≤ J (J = cfg_sjw+1), or B < 2. While cfg_err is high, the unit times bits with P=3, A=3, B=3, J=1 and keeps cfg_brp.
- R6: With sof_en = 1, a falling rx edge restarts the grid at any point: the prescaler restarts and the current quantum becomes the sync segment. bit_start rises on the second clock edge after rx goes low.
- R7: With sof_en = 0, a falling edge seen in quantum q (1 ≤ q ≤ P+A) lengthens phase 1 by min(q, J) quanta. The sample point and the bit end move by that amount.
- R8: With sof_en = 0, a falling edge seen in phase 2 at quantum q has an error of e = (1+P+A+B) − q. If e > J, phase 2 is shortened by J quanta. Otherwise the bit restarts, and bit_start rises on the second clock edge after rx goes low.
- R9: A falling edge seen in the sync quantum (q = 0) changes neither the sample point nor the bit length.
- R10: At most one resynchronization happens per bit. Once a bit has sampled a dominant level, no phase-2 edge in that bit changes its length.
- R11: sample_pulse and bit_start are never high in the same clock, and neither stays high for two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_brp | input | 6 | Prescaler value; one quantum is 2·(value+1) clocks |
| cfg_prop | input | 3 | Propagation segment length minus one |
| cfg_ps1 | input | 3 | Phase segment 1 length minus one |
| cfg_ps2 | input | 3 | Phase segment 2 length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_triple | input | 1 | 1 selects three-sample majority |
| rx | input | 1 | Raw receive line, 1 = recessive |
| sof_en | input | 1 | Bus idle: edges hard-synchronize instead of resynchronizing |
| rx_bit | output | 1 | Value of the last sampled bit |
| sample_pulse | output | 1 | One-clock strobe when rx_bit is updated |
| bit_start | output | 1 | One-clock strobe in the first clock of each bit |
| cfg_err | output | 1 | Timing rules violated; fallback timing in use |

## Verification
The sample-point tick and a resynchronization edge can land in the same clock. The unit must then apply the lengthening before deciding whether to sample. The bench provokes this by making rx fall so that the edge is detected in the last clock of phase segment 1. The check passes if no strobe appears at the nominal point, a dominant sample arrives two quanta later, and the bit grows by two quanta. A second overlap tested is a phase-2 edge arriving in a bit that has already sampled dominant. There the resynchronization must be suppressed, and the bit length stays nominal.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int DEF_PROP   = 3;
  localparam int DEF_PS1    = 3;
  localparam int DEF_PS2    = 3;
  localparam int DEF_SJW    = 1;
  localparam int MIN_BIT_TQ = 8;
  localparam int MAX_BIT_TQ = 25;
  localparam int MIN_PS2_TQ = 2;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  input  logic             clr,
  output logic             tq_tick,
  output logic             half_tick
);
  localparam int PC_W = BRP_W + 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] limit;

  always_comb begin
    limit     = {brp, 1'b1};
    tq_tick   = (pc >= limit);
    half_tick = tq_tick || (pc == {1'b0, brp});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= '0;
    else if (clr)      pc <= '0;
    else if (tq_tick)  pc <= '0;
    else               pc <= pc + PC_W'(1);
  end
endmodule

// File: rtl/cbt_cfg_check.sv
module cbt_cfg_check
  import cbt_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ps1,
  input  logic [SEG_W-1:0] cfg_ps2,
  input  logic [SJW_W-1:0] cfg_sjw,
  output logic             err,
  output logic [SEG_W:0]   prop_len,
  output logic [SEG_W:0]   ps1_len,
  output logic [SEG_W:0]   ps2_len,
  output logic [SJW_W:0]   sjw_len
);
  localparam int LEN_W = SEG_W + 1;
  localparam int TOT_W = LEN_W + 2;

  logic [LEN_W-1:0] p, a, b;
  logic [SJW_W:0]   j;
  logic [TOT_W-1:0] total, front;

  always_comb begin
    p     = LEN_W'(cfg_prop) + LEN_W'(1);
    a     = LEN_W'(cfg_ps1) + LEN_W'(1);
    b     = LEN_W'(cfg_ps2) + LEN_W'(1);
    j     = (SJW_W+1)'(cfg_sjw) + (SJW_W+1)'(1);
    front = TOT_W'(p) + TOT_W'(a);
    total = front + TOT_W'(b) + TOT_W'(1);
    err   = (total < TOT_W'(MIN_BIT_TQ)) || (total > TOT_W'(MAX_BIT_TQ)) ||
            (front < TOT_W'(b)) || (TOT_W'(b) <= TOT_W'(j)) ||
            (b < LEN_W'(MIN_PS2_TQ));
    if (err) begin
      prop_len = LEN_W'(DEF_PROP);
      ps1_len  = LEN_W'(DEF_PS1);
      ps2_len  = LEN_W'(DEF_PS2);
      sjw_len  = (SJW_W+1)'(DEF_SJW);
    end else begin
      prop_len = p;
      ps1_len  = a;
      ps2_len  = b;
      sjw_len  = j;
    end
  end
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
  import cbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  input  logic half_tick,
  input  logic take,
  input  logic triple,
  output logic sample_val,
  output logic rx_bit,
  output logic sample_pulse
);
  logic [1:0] hist;

  always_comb
    sample_val = triple ? maj3(hist[1], hist[0], rx_s) : rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist         <= 2'b11;
      rx_bit       <= 1'b1;
      sample_pulse <= 1'b0;
    end else begin
      if (half_tick) hist <= {hist[0], rx_s};
      sample_pulse <= take;
      if (take) rx_bit <= sample_val;
    end
  end
endmodule

// File: rtl/cbt_sequencer.sv
module cbt_sequencer #(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tq_tick,
  input  logic           fall_det,
  input  logic           sof_en,
  input  logic [SEG_W:0] prop_len,
  input  logic [SEG_W:0] ps1_len,
  input  logic [SEG_W:0] ps2_len,
  input  logic [SJW_W:0] sjw_len,
  input  logic           sample_val,
  output logic           take,
  output logic           hard,
  output logic           bit_start
);
  localparam int Q_W = SEG_W + 3;

  logic [Q_W-1:0] q;
  logic [SJW_W:0] ext, shr, ext_n, shr_n, q_cap;
  logic           used, dom;
  logic [Q_W-1:0] sp_base, last_base, sp_n, last_n, err2;
  logic           allowed, lengthen, shorten_ok, shorten, restart, endb;

  always_comb begin
    sp_base    = Q_W'(prop_len) + Q_W'(ps1_len);
    last_base  = sp_base + Q_W'(ps2_len);
    hard       = fall_det && sof_en;
    allowed    = fall_det && !sof_en && !used;
    lengthen   = allowed && (q != '0) && (q <= sp_base);
    err2       = last_base + Q_W'(1) - q;
    shorten_ok = allowed && (q > sp_base) && !dom;
    restart    = shorten_ok && (err2 <= Q_W'(sjw_len));
    shorten    = shorten_ok && !restart;
    q_cap      = (q < Q_W'(sjw_len)) ? q[SJW_W:0] : sjw_len;
    ext_n      = lengthen ? q_cap : ext;
    shr_n      = shorten ? sjw_len : shr;
    sp_n       = sp_base + Q_W'(ext_n);
    last_n     = last_base + Q_W'(ext_n) - Q_W'(shr_n);
    take       = tq_tick && (q == sp_n) && !hard && !restart;
    endb       = tq_tick && (q >= last_n) && !hard && !restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q         <= '0;
      ext       <= '0;
      shr       <= '0;
      used      <= 1'b0;
      dom       <= 1'b0;
      bit_start <= 1'b0;
    end else if (hard || restart || endb) begin
      q         <= '0;
      ext       <= '0;
      shr       <= '0;
      used      <= 1'b0;
      dom       <= 1'b0;
      bit_start <= 1'b1;
    end else begin
      if (tq_tick) q <= q + Q_W'(1);
      ext       <= ext_n;
      shr       <= shr_n;
      used      <= used | lengthen | shorten;
      dom       <= dom | (take & ~sample_val);
      bit_start <= 1'b0;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ps1,
  input  logic [SEG_W-1:0] cfg_ps2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             cfg_triple,
  input  logic             rx,
  input  logic             sof_en,
  output logic             rx_bit,
  output logic             sample_pulse,
  output logic             bit_start,
  output logic             cfg_err
);
  logic           rx_s, rx_d, fall_det;
  logic           tq_tick, half_tick, take, hard, sample_val;
  logic [SEG_W:0] prop_len, ps1_len, ps2_len;
  logic [SJW_W:0] sjw_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_s <= rx;
      rx_d <= rx_s;
    end
  end

  always_comb fall_det = rx_d & ~rx_s;

  cbt_cfg_check #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_cfg (
    .cfg_prop(cfg_prop), .cfg_ps1(cfg_ps1), .cfg_ps2(cfg_ps2), .cfg_sjw(cfg_sjw),
    .err(cfg_err), .prop_len(prop_len), .ps1_len(ps1_len), .ps2_len(ps2_len),
    .sjw_len(sjw_len)
  );

  cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .brp(cfg_brp), .clr(hard),
    .tq_tick(tq_tick), .half_tick(half_tick)
  );

  cbt_sequencer #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .fall_det(fall_det),
    .sof_en(sof_en), .prop_len(prop_len), .ps1_len(ps1_len), .ps2_len(ps2_len),
    .sjw_len(sjw_len), .sample_val(sample_val), .take(take), .hard(hard),
    .bit_start(bit_start)
  );

  cbt_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .half_tick(half_tick), .take(take),
    .triple(cfg_triple), .sample_val(sample_val), .rx_bit(rx_bit),
    .sample_pulse(sample_pulse)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx,
  input logic cfg_triple,
  input logic rx_bit,
  input logic sample_pulse,
  input logic bit_start
);
  assert_strobes_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pulse && bit_start));

  assert_sample_one_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> !sample_pulse);

  assert_start_one_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> !bit_start);

  assert_bit_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> sample_pulse);

  assert_single_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pulse && !$past(cfg_triple)) |-> (rx_bit == $past(rx, 2)));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx(rx), .cfg_triple(cfg_triple),
  .rx_bit(rx_bit), .sample_pulse(sample_pulse), .bit_start(bit_start)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // brp, prop, ps1, ps2, sjw (lengths), expected err, bit clocks, sample offset
  localparam int VEC [NV][8] = '{
    '{0,  2, 3, 2, 1, 0, 16,   12},
    '{1,  3, 4, 4, 2, 0, 48,   32},
    '{0,  8, 8, 8, 4, 0, 50,   34},
    '{0,  1, 2, 2, 1, 1, 20,   14},
    '{0,  1, 1, 8, 1, 1, 20,   14},
    '{0,  4, 4, 3, 3, 1, 20,   14},
    '{0,  4, 3, 1, 1, 1, 20,   14},
    '{2,  1, 5, 2, 1, 0, 54,   42},
    '{0,  4, 2, 6, 1, 0, 26,   14},
    '{63, 2, 3, 2, 1, 0, 1024, 768}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_brp = '0;
  logic [2:0] cfg_prop = '0, cfg_ps1 = '0, cfg_ps2 = '0;
  logic [1:0] cfg_sjw = '0;
  logic       cfg_triple = 1'b0;
  logic       rx = 1'b1;
  logic       sof_en = 1'b0;
  logic       rx_bit, sample_pulse, bit_start, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  can_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_prop(cfg_prop),
    .cfg_ps1(cfg_ps1), .cfg_ps2(cfg_ps2), .cfg_sjw(cfg_sjw),
    .cfg_triple(cfg_triple), .rx(rx), .sof_en(sof_en), .rx_bit(rx_bit),
    .sample_pulse(sample_pulse), .bit_start(bit_start), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int brp, input int p, input int a, input int b, input int j);
    cfg_brp  = 6'(brp);
    cfg_prop = 3'(p - 1);
    cfg_ps1  = 3'(a - 1);
    cfg_ps2  = 3'(b - 1);
    cfg_sjw  = 2'(j - 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Counts clocks from a bit_start (t=0) to the first sample strobe and the next bit_start.
  task automatic run_bit(input bit skip, input int ta, input logic va,
                         input int tb, input logic vb, input int tc, input logic vc,
                         output int sp_t, output int bs_t, output int bv);
    int  t;
    bit  ovl;
    sp_t = -1; bs_t = -1; bv = -1; ovl = 1'b0; t = 0;
    if (!skip) begin
      @(negedge clk);
      while (!bit_start) @(negedge clk);
    end
    while (t < 2000 && bs_t < 0) begin
      if (t == ta) rx = va;
      if (t == tb) rx = vb;
      if (t == tc) rx = vc;
      @(negedge clk);
      t++;
      if (sample_pulse && bit_start) ovl = 1'b1;
      if (sample_pulse && sp_t < 0) begin
        sp_t = t;
        bv = int'(rx_bit);
      end
      if (bit_start) bs_t = t;
    end
    chk_eq("R11 strobe overlap", int'(ovl), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int sp_t, bs_t, bv;

    // Reset state
    set_cfg(0, 2, 3, 4, 2);
    do_reset();
    chk_eq("R11 reset bit_start", int'(bit_start), 0);
    chk_eq("R2 reset sample_pulse", int'(sample_pulse), 0);
    chk_eq("R2 reset rx_bit", int'(rx_bit), 1);
    chk_eq("R5 reset cfg_err", int'(cfg_err), 0);

    // Table of configurations, free-running bits with the line recessive
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      rx = 1'b1;
      sof_en = 1'b0;
      do_reset();
      chk_eq("R5 cfg_err", int'(cfg_err), VEC[i][5]);
      run_bit(1'b0, -1, 1'b1, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
      chk_eq("R1 bit length", bs_t, VEC[i][6]);
      chk_eq("R2 sample offset", sp_t, VEC[i][7]);
    end

    // Directed: prop 2, ps1 3, ps2 4, sjw 2, quantum of 2 clocks
    set_cfg(0, 2, 3, 4, 2);
    cfg_triple = 1'b0;
    rx = 1'b1;
    sof_en = 1'b1;
    do_reset();

    // R6 hard synchronization in the middle of a bit
    repeat (7) @(negedge clk);
    rx = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk_eq("R6 hard sync bit_start", int'(bit_start), 1);
    run_bit(1'b1, -1, 1'b1, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
    chk_eq("R6 sample after hard sync", sp_t, 12);
    chk_eq("R6 bit after hard sync", bs_t, 20);

    rx = 1'b1;
    sof_en = 1'b0;
    // R7 edge in quantum 2: lengthen by 2
    run_bit(1'b0, 3, 1'b0, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
    chk_eq("R7 q2 sample", sp_t, 16);
    chk_eq("R7 q2 bit", bs_t, 24);
    chk_eq("R7 q2 value", bv, 0);

    rx = 1'b1;
    // R7 edge in quantum 4: lengthen capped at jump width 2
    run_bit(1'b0, 7, 1'b0, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
    chk_eq("R7 q4 capped sample", sp_t, 16);
    chk_eq("R7 q4 capped bit", bs_t, 24);

    rx = 1'b1;
    // R7 edge in quantum 1: lengthen by 1
    run_bit(1'b0, 1, 1'b0, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
    chk_eq("R7 q1 sample", sp_t, 14);
    chk_eq("R7 q1 bit", bs_t, 22);

    rx = 1'b1;
    // R7 edge detected in the clock of the sample-point tick
    run_bit(1'b0, 10, 1'b0, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
    chk_eq("R7 coincident sample", sp_t, 16);
    chk_eq("R7 coincident bit", bs_t, 24);
    chk_eq("R7 coincident value", bv, 0);

    rx = 1'b1;
    // R8 edge in phase 2 quantum 6: error 4 > 2, shorten by 2
    run_bit(1'b0, 11, 1'b0, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
    chk_eq("R8 shorten sample", sp_t, 12);
    chk_eq("R8 shorten value", bv, 1);
    chk_eq("R8 shorten bit", bs_t, 16);

    rx = 1'b1;
    // R8 edge in phase 2 quantum 9: error 1 <= 2, restart
    run_bit(1'b0, 17, 1'b0, -1, 1'b1, -1, 1'b1, sp_t, bs_t, bv);
    chk_eq("R8 restart sample", sp_t, 12);
    chk_eq("R8 restart bit", bs_t, 19);

    rx = 1'b1;
    // R9 edge in sync quantum; R10 later phase-2 edge after dominant sample
    run_bit(1'b0, 0, 1'b0, 13, 1'b1, 15, 1'b0, sp_t, bs_t, bv);
    chk_eq("R9 sync edge sample", sp_t, 12);
    chk_eq("R9 sync edge value", bv, 0);
    chk_eq("R10 dominant blocks resync", bs_t, 20);

    rx = 1'b1;
    // R10 second phase-1 edge in the same bit is ignored
    run_bit(1'b0, 1, 1'b0, 3, 1'b1, 5, 1'b0, sp_t, bs_t, bv);
    chk_eq("R10 one resync sample", sp_t, 14);
    chk_eq("R10 one resync bit", bs_t, 22);

    // Triple sampling, quantum of 4 clocks, half tick every 2
    set_cfg(1, 2, 3, 4, 2);
    cfg_triple = 1'b1;
    rx = 1'b1;
    sof_en = 1'b0;
    do_reset();
    run_bit(1'b0, 0, 1'b0, 22, 1'b1, 23, 1'b0, sp_t, bs_t, bv);
    chk_eq("R4 triple sample time", sp_t, 24);
    chk_eq("R4 triple rejects one-sample glitch", bv, 0);

    rx = 1'b1;
    run_bit(1'b0, 0, 1'b0, 20, 1'b1, 23, 1'b0, sp_t, bs_t, bv);
    chk_eq("R4 triple two of three recessive", bv, 1);

    rx = 1'b1;
    cfg_triple = 1'b0;
    run_bit(1'b0, 0, 1'b0, 22, 1'b1, 23, 1'b0, sp_t, bs_t, bv);
    chk_eq("R3 single sample sees glitch", bv, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule